// File: doc/BRIEF.md
# Windowed Watchdog Timer Controller

This block is a watchdog with a 16-bit control word. The word enables the timer and picks which tick-enable input advances the counter. It also holds two separate timeout exponents, one for normal operation and one for sleep, and an optional service window. When the timer is enabled, the counter advances on each tick of the selected source. If software does not service the timer before the counter reaches the end of its period, the block raises a one-cycle reset request.

In window mode the service strobe is only legal in the late part of the period. A strobe that arrives too early is treated as a fault and also raises the reset request. After the timer is switched on, every configuration field is frozen and only the enable bit can still change. The whole word is loaded at reset from a configuration vector. The word can be read back at any time through a combinational read port.

Top module: `wdt_window_ctrl`

## Requirements
- R1: While `rst_n` is low, the control word loads from `cfg_init` and `rst_req` is 0. `rd_data` always shows the control word. Its layout is: bit 15 enable, bits 14:13 window code, bits 12:8 awake exponent, bits 7:6 tick select, bits 5:1 sleep exponent, bit 0 window bypass.
- R2: While the enable bit is 0, a write replaces the whole word. While it is 0, the counter is held at zero and `rst_req` stays 0. Switching the timer off and on again restarts the count from zero.
- R3: While the enable bit is 1, a write changes only bit 15, and bits 14:0 keep their values.
- R4: With exponent P, the period is 2^P selected ticks. When the tick taken at count 2^P-1 arrives with no service strobe, `rst_req` is high for exactly the one cycle after that clock edge, and counting restarts at zero.
- R5: An exponent above 20 acts as 20 (the `CNT_W` default), and the stored field keeps the written value.
- R6: Tick select 00 counts `tick_sys4`, 10 counts `tick_bkup` and 11 counts `tick_lp`. Code 01 counts nothing, so no timeout can occur.
- R7: While `sleep_i` is 1, bits 5:1 give the exponent. Otherwise bits 12:8 give it.
- R8: With window checking on (bit 0 = 0), a service strobe is legal when count >= floor(n*2^P/8). Here n is 6, 5, 4 or 2 for window codes 11, 10, 01 or 00. A legal strobe restarts the count and raises no request.
- R9: With window checking on, a strobe below that threshold raises `rst_req` for one cycle (the cycle after the edge) and restarts the count.
- R10: With bit 0 = 1, a service strobe is accepted at any count.
- R11: When a service strobe and a terminal tick fall in the same cycle, the strobe wins, so no timeout is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| cfg_init | input | 16 | Control word loaded at reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current control word |
| svc_clr | input | 1 | Service (clear) strobe, one cycle |
| sleep_i | input | 1 | Sleep indication, selects the sleep exponent |
| tick_sys4 | input | 1 | Tick enable from the divided system clock |
| tick_bkup | input | 1 | Tick enable from the backup oscillator |
| tick_lp | input | 1 | Tick enable from the low-power oscillator |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The properties assume that the tick and service inputs are single-cycle strobes, synchronous to `clk`. They also assume that the control word is only ever observed through `rd_data`. Because of this, rules such as the write lock and "no request while off" are stated on `rd_data` and `rst_req` from one cycle to the next. The stimulus drives every input at the falling edge and uses only small exponents, so each period and window edge falls within a few dozen cycles. Before any field change it first writes the enable bit to 0, then loads the fields and then enables the timer, so no configuration write is silently lost to the lock unless the test intends that.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int CTRL_W = 16;
  localparam int PS_W   = 5;

  // Field order is fixed by the bit positions of the control word.
  typedef struct packed {
    logic            on;
    logic [1:0]      win;
    logic [PS_W-1:0] run_ps;
    logic [1:0]      tick_sel;
    logic [PS_W-1:0] slp_ps;
    logic            win_off;
  } wdt_ctrl_t;

  typedef enum logic [1:0] {
    TS_SYS4 = 2'b00,
    TS_NONE = 2'b01,
    TS_BKUP = 2'b10,
    TS_LP   = 2'b11
  } wdt_tsel_e;

  // Window start in eighths of the period.
  function automatic logic [3:0] win_eighths(input logic [1:0] code);
    case (code)
      2'b11:   return 4'd6;
      2'b10:   return 4'd5;
      2'b01:   return 4'd4;
      default: return 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] cfg_init,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output wdt_ctrl_t         ctrl_q
);

  wdt_ctrl_t ctrl_d;
  wdt_ctrl_t wr_word;

  assign wr_word = wdt_ctrl_t'(wr_data);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_q.on) begin
      ctrl_d.on = wr_word.on;
    end else begin
      ctrl_d = wr_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= wdt_ctrl_t'(cfg_init);
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
  import wdt_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       tick_sys4,
  input  logic       tick_bkup,
  input  logic       tick_lp,
  output logic       tick
);

  always_comb begin
    case (wdt_tsel_e'(sel))
      TS_SYS4: tick = tick_sys4;
      TS_BKUP: tick = tick_bkup;
      TS_LP:   tick = tick_lp;
      default: tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [PS_W-1:0] ps,
  input  logic [1:0]      win,
  input  logic            win_off,
  input  logic            tick,
  input  logic            clr,
  output logic            rst_req
);

  localparam int              EXT_W  = CNT_W + 4;
  localparam logic [PS_W-1:0] PS_MAX = PS_W'(CNT_W);

  logic [PS_W-1:0]  ps_eff;
  logic [CNT_W:0]   term_wide;
  logic [EXT_W-1:0] thr_wide;
  logic             in_win;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_d;
  logic             cnt_en;

  assign ps_eff    = (ps > PS_MAX) ? PS_MAX : ps;
  assign term_wide = ((CNT_W+1)'(1) << ps_eff) - (CNT_W+1)'(1);
  assign thr_wide  = (EXT_W'(win_eighths(win)) << ps_eff) >> 3;
  assign in_win    = (EXT_W'(cnt_q) >= thr_wide);

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (!enable) begin
      cnt_d = '0;
    end else if (clr) begin
      cnt_d = '0;
      req_d = !(win_off || in_win);
    end else if (tick) begin
      if ({1'b0, cnt_q} == term_wide) begin
        cnt_d = '0;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_en = !enable || clr || tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
    end else begin
      rst_req <= req_d;
    end
  end

endmodule

// File: rtl/wdt_window_ctrl.sv
module wdt_window_ctrl
  import wdt_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_init,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        svc_clr,
  input  logic        sleep_i,
  input  logic        tick_sys4,
  input  logic        tick_bkup,
  input  logic        tick_lp,
  output logic        rst_req
);

  wdt_ctrl_t       ctrl_q;
  logic            tick_sel;
  logic [PS_W-1:0] ps_cur;

  wdt_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_init (cfg_init),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q)
  );

  wdt_tick_sel u_tsel (
    .sel       (ctrl_q.tick_sel),
    .tick_sys4 (tick_sys4),
    .tick_bkup (tick_bkup),
    .tick_lp   (tick_lp),
    .tick      (tick_sel)
  );

  assign ps_cur = sleep_i ? ctrl_q.slp_ps : ctrl_q.run_ps;

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (ctrl_q.on),
    .ps      (ps_cur),
    .win     (ctrl_q.win),
    .win_off (ctrl_q.win_off),
    .tick    (tick_sel),
    .clr     (svc_clr),
    .rst_req (rst_req)
  );

  assign rd_data = ctrl_q;

endmodule

// File: rtl/wdt_window_ctrl_chk.sv
module wdt_window_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        svc_clr,
  input logic        rst_req
);

  assert_locked_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15] && wr_en) |=> (rd_data[14:0] == $past(rd_data[14:0])));

  assert_off_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[15]) |=> !rd_data[15]);

  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[15] |=> !rst_req);

  assert_no_tick_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15] && rd_data[7:6] == 2'b01 && !svc_clr) |=> !rst_req);

  assert_bypass_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15] && rd_data[0] && svc_clr) |=> !rst_req);

endmodule

bind wdt_window_ctrl wdt_window_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .svc_clr (svc_clr),
  .rst_req (rst_req)
);

// File: tb/wdt_window_ctrl_tb_top.sv
module wdt_window_ctrl_tb_top;

  localparam int          CLK_P = 10;
  localparam logic [15:0] INIT  = 16'h2305;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        svc_clr;
  logic        sleep_i;
  logic        tick_sys4;
  logic        tick_bkup;
  logic        tick_lp;
  logic        rst_req;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  bit    q_exp[$];
  string q_tag[$];

  logic [15:0] m_cfg;
  int          m_cnt;

  wdt_window_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_init  (INIT),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .svc_clr   (svc_clr),
    .sleep_i   (sleep_i),
    .tick_sys4 (tick_sys4),
    .tick_bkup (tick_bkup),
    .tick_lp   (tick_lp),
    .rst_req   (rst_req)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compares the request output after each edge with the queued expectation.
  always @(posedge clk) begin
    #(CLK_P/4);
    if (q_exp.size() > 0) begin
      bit    e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      chk(rst_req == e, t, {31'b0, rst_req}, {31'b0, e});
    end
  end

  function automatic logic [15:0] mk(input bit on, input logic [1:0] win, input logic [4:0] rps,
                                     input logic [1:0] sel, input logic [4:0] sps, input bit wdis);
    return {on, win, rps, sel, sps, wdis};
  endfunction

  // Driver: one cycle of stimulus plus the expected request, from the requirements.
  task automatic cyc(input bit ts, input bit tb, input bit tl, input bit cl, input bit sl,
                     input bit w, input logic [15:0] wd, input string tag);
    int  p, num, thr, term;
    bit  tk, e;
    @(negedge clk);
    tick_sys4 = ts; tick_bkup = tb; tick_lp = tl;
    svc_clr = cl; sleep_i = sl; wr_en = w; wr_data = wd;
    p = sl ? int'(m_cfg[5:1]) : int'(m_cfg[12:8]);
    if (p > 20) p = 20;
    case (m_cfg[14:13])
      2'b11: num = 6;
      2'b10: num = 5;
      2'b01: num = 4;
      default: num = 2;
    endcase
    thr  = (num << p) / 8;
    term = (1 << p) - 1;
    case (m_cfg[7:6])
      2'b00: tk = ts;
      2'b10: tk = tb;
      2'b11: tk = tl;
      default: tk = 1'b0;
    endcase
    e = 1'b0;
    if (!m_cfg[15]) begin
      m_cnt = 0;
    end else if (cl) begin
      e = !(m_cfg[0] || m_cnt >= thr);
      m_cnt = 0;
    end else if (tk) begin
      if (m_cnt == term) begin
        e = 1'b1;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end
    if (w) begin
      if (m_cfg[15]) m_cfg[15] = wd[15];
      else m_cfg = wd;
    end
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic run(input int n, input bit ts, input bit tb, input bit tl, input bit sl, input string tag);
    for (int i = 0; i < n; i++) cyc(ts, tb, tl, 1'b0, sl, 1'b0, 16'h0, tag);
  endtask

  task automatic wr(input logic [15:0] v, input string tag);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, v, tag);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, tag);
  endtask

  task automatic clr(input bit ts, input bit sl, input string tag);
    cyc(ts, 1'b0, 1'b0, 1'b1, sl, 1'b0, 16'h0, tag);
  endtask

  // Off, load fields while off, then enable.
  task automatic cfg_on(input logic [15:0] v, input string tag);
    wr({1'b0, v[14:0]}, tag);
    wr({1'b0, v[14:0]}, tag);
    chk(rd_data == {1'b0, v[14:0]}, {tag, " load"}, {16'b0, rd_data}, {17'b0, v[14:0]});
    wr({1'b1, v[14:0]}, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; svc_clr = 1'b0;
    sleep_i = 1'b0; tick_sys4 = 1'b0; tick_bkup = 1'b0; tick_lp = 1'b0;
    m_cfg = INIT; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk(rd_data == INIT, "R1 reset word", {16'b0, rd_data}, {16'b0, INIT});
    chk(rst_req == 1'b0, "R1 reset request", {31'b0, rst_req}, 32'd0);
    rst_n = 1'b1;

    // R2: write while off replaces the whole word
    wr(mk(0, 2'b10, 5'd6, 2'b11, 5'd4, 1'b0), "R2 off write");
    chk(rd_data == mk(0, 2'b10, 5'd6, 2'b11, 5'd4, 1'b0), "R2 off write readback",
        {16'b0, rd_data}, {16'b0, mk(0, 2'b10, 5'd6, 2'b11, 5'd4, 1'b0)});
    run(20, 1, 1, 1, 0, "R2 off no request");

    // R4: period of 2^3 ticks on the divided system tick
    cfg_on(mk(1, 2'b01, 5'd3, 2'b00, 5'd2, 1'b1), "R4 setup");
    run(20, 1, 0, 0, 0, "R4 timeout");
    run(5, 0, 0, 0, 0, "R4 idle holds");
    run(6, 1, 0, 0, 0, "R4 timeout resume");

    // R3: lock while on
    wr(mk(1, 2'b10, 5'd7, 2'b11, 5'd9, 1'b0), "R3 locked write");
    chk(rd_data == mk(1, 2'b01, 5'd3, 2'b00, 5'd2, 1'b1), "R3 fields unchanged",
        {16'b0, rd_data}, {16'b0, mk(1, 2'b01, 5'd3, 2'b00, 5'd2, 1'b1)});
    wr(mk(0, 2'b11, 5'd1, 2'b10, 5'd1, 1'b0), "R3 on-bit only");
    chk(rd_data == mk(0, 2'b01, 5'd3, 2'b00, 5'd2, 1'b1), "R3 only enable cleared",
        {16'b0, rd_data}, {16'b0, mk(0, 2'b01, 5'd3, 2'b00, 5'd2, 1'b1)});

    // R2: disable clears the counter
    cfg_on(mk(1, 2'b01, 5'd3, 2'b00, 5'd2, 1'b1), "R2 restart setup");
    run(5, 1, 0, 0, 0, "R2 partial count");
    wr(mk(0, 2'b01, 5'd3, 2'b00, 5'd2, 1'b1), "R2 off");
    wr(mk(1, 2'b01, 5'd3, 2'b00, 5'd2, 1'b1), "R2 on");
    run(9, 1, 0, 0, 0, "R2 full period after restart");

    // R6: tick source selection
    cfg_on(mk(1, 2'b01, 5'd2, 2'b10, 5'd2, 1'b1), "R6 bkup setup");
    run(10, 1, 0, 1, 0, "R6 bkup ignores others");
    run(8, 0, 1, 0, 0, "R6 bkup counts");
    cfg_on(mk(1, 2'b01, 5'd2, 2'b11, 5'd2, 1'b1), "R6 lp setup");
    run(10, 1, 1, 0, 0, "R6 lp ignores others");
    run(8, 0, 0, 1, 0, "R6 lp counts");
    cfg_on(mk(1, 2'b01, 5'd0, 2'b01, 5'd0, 1'b1), "R6 reserved setup");
    run(30, 1, 1, 1, 0, "R6 reserved no ticks");
    run(30, 1, 1, 1, 1, "R6 reserved no ticks asleep");

    // R7: sleep exponent
    cfg_on(mk(1, 2'b01, 5'd5, 2'b00, 5'd2, 1'b1), "R7 setup");
    run(6, 1, 0, 0, 1, "R7 sleep period");
    run(10, 1, 0, 0, 0, "R7 awake period");
    run(25, 1, 0, 0, 0, "R7 awake timeout");

    // R8 and R9: every window code, just below and at the threshold
    for (int w = 0; w < 4; w++) begin
      int thr;
      thr = (w == 3) ? 12 : (w == 2) ? 10 : (w == 1) ? 8 : 4;
      cfg_on(mk(1, 2'(w), 5'd4, 2'b00, 5'd2, 1'b0), "R8 setup");
      run(thr - 1, 1, 0, 0, 0, "R9 count below window");
      clr(1'b0, 1'b0, "R9 early clear");
      run(thr, 1, 0, 0, 0, "R8 count to window");
      clr(1'b0, 1'b0, "R8 legal clear");
      run(thr, 1, 0, 0, 0, "R8 count after clear");
    end

    // R10: bypass accepts a clear at any count
    cfg_on(mk(1, 2'b11, 5'd3, 2'b00, 5'd2, 1'b1), "R10 setup");
    run(1, 1, 0, 0, 0, "R10 one tick");
    clr(1'b0, 1'b0, "R10 early clear accepted");
    clr(1'b0, 1'b0, "R10 clear at zero accepted");

    // R11: clear beats a terminal tick
    run(7, 1, 0, 0, 0, "R11 reach terminal");
    clr(1'b1, 1'b0, "R11 clear wins over tick");
    run(8, 1, 0, 0, 0, "R11 full period after");

    // R5: exponent clamp
    cfg_on(mk(1, 2'b01, 5'd31, 2'b00, 5'd2, 1'b0), "R5 setup");
    chk(rd_data[12:8] == 5'd31, "R5 field kept", {27'b0, rd_data[12:8]}, 32'd31);
    run(3, 1, 0, 0, 0, "R5 count");
    clr(1'b0, 1'b0, "R5 clamped window still closed");
    run(40, 1, 0, 0, 0, "R5 no early timeout");

    run(3, 0, 0, 0, 0, "drain");
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule